// File: doc/BRIEF.md
# Segment Address Translation and Protection Unit

This unit sits between a core's 32-bit logical address space and a 36-bit physical address space. It holds a set of programmable segment descriptors. Each descriptor names a logical base, a power-of-two segment size, a physical replacement base and six access-permission bits. A lookup presents a logical address, an access kind and a privilege level. The unit compares the address with every enabled segment in parallel and picks the highest-numbered segment that matches. It returns the translated physical address, a hit flag and a fault flag. The fault flag is raised when the chosen segment does not allow the requested access.

Software programs the descriptors through a 32-bit word-write port and reads them back through a combinational read port. The port uses byte offsets from the block base. With the default parameters the lookup result is registered, so it appears one clock after the request. A parameter selects a purely combinational variant instead.

Top module: `segx_unit`

## Requirements
- R1: After reset, every descriptor word reads back as zero and every lookup misses, with hit = 0 and fault = 0.
- R2: Segment N occupies byte offsets N*8 and N*8+4. The word at N*8 holds the size code in bits [4:0] and the logical base in bits [31:12]. The word at N*8+4 holds the permission field in bits [7:0] and the physical base, meaning physical address bits [35:12], in bits [31:8]. A write stores the word and a read returns it.
- R3: Reserved bits always read back as zero, even after writing ones: bits [11:5] of the N*8 word and bits [7:6] of the N*8+4 word.
- R4: A size code C gives a segment of 2^(C+1) bytes. The smallest size is 4 KB (C = 0x0B) and C = 0x1F covers all 4 GB. A code below 0x0B disables the segment, so it never matches.
- R5: For a segment of size 2^n, only logical address bits [31:n] are compared with the same bits of the logical base.
- R6: On a hit, physical bits [35:n] come from the physical base and bits [n-1:0] are the logical address bits unchanged. For example, a 1 GB segment at logical 0x80000000 with physical base field 0x040000 maps logical 0x80000010 to 0x0_4000_0010.
- R7: When several enabled segments match, the highest-numbered one supplies the address and the permissions.
- R8: Access kind encoding is 0 = read, 1 = write, 2 = execute, and 3 is always denied. Privilege 1 = supervisor, 0 = user. Permission bits from bit 0 upward are user-execute, user-write, user-read, supervisor-execute, supervisor-write, supervisor-read. On a hit, fault = 1 exactly when the bit for the requested kind and privilege is 0.
- R9: A lookup that matches no enabled segment gives hit = 0 and fault = 0. The physical output is then undefined.
- R10: In the default registered variant, res_valid, res_hit, res_fault and res_paddr describe the request that lk_valid qualified on the previous clock edge. res_valid is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Descriptor word write strobe |
| cfg_addr | input | 7 | Byte offset of the descriptor word (bits [1:0] ignored) |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Combinational read-back of the word at cfg_addr |
| lk_valid | input | 1 | Lookup request qualifier |
| lk_addr | input | 32 | Logical address |
| lk_acc | input | 2 | Access kind (0 read, 1 write, 2 execute, 3 denied) |
| lk_priv | input | 1 | 1 = supervisor, 0 = user |
| res_valid | output | 1 | Lookup result valid |
| res_hit | output | 1 | An enabled segment matched |
| res_fault | output | 1 | Matching segment denies the access |
| res_paddr | output | 36 | Translated physical address |

## Verification
A descriptor write takes effect at the clock edge that samples cfg_we, and read-back is combinational. The bench therefore reads a word back at the falling edge after the write, once the new value has settled. In the default variant a lookup driven at a falling edge is captured at the next rising edge. All four result ports are sampled at the falling edge that follows, which is the only cycle in which res_valid is high for that request. res_valid is checked again one cycle later to confirm that it drops. The physical address is compared only when a hit is expected, because R9 leaves it undefined on a miss.

// File: rtl/segx_pkg.sv
package segx_pkg;

   localparam int unsigned LA_W    = 32;
   localparam int unsigned PAGE_W  = 12;
   localparam int unsigned LBASE_W = LA_W - PAGE_W;
   localparam int unsigned PBASE_W = 24;
   localparam int unsigned PA_W    = PBASE_W + PAGE_W;
   localparam int unsigned CODE_W  = 5;
   localparam int unsigned PERM_W  = 6;
   localparam logic [CODE_W-1:0] MIN_CODE = 5'h0B;

   typedef enum logic [1:0] {
      ACC_READ  = 2'd0,
      ACC_WRITE = 2'd1,
      ACC_EXEC  = 2'd2,
      ACC_RSVD  = 2'd3
   } acc_e;

   typedef struct packed {
      logic [LBASE_W-1:0] lbase;
      logic [CODE_W-1:0]  code;
      logic [PBASE_W-1:0] pbase;
      logic [PERM_W-1:0]  perm;
   } seg_desc_t;

   // Bits of the logical address that take part in the compare: [31:code+1].
   function automatic logic [LA_W-1:0] cmp_mask(input logic [CODE_W-1:0] code);
      logic [LA_W-1:0] m;
      logic [CODE_W:0] n;
      n = {1'b0, code} + 1'b1;
      for (int i = 0; i < int'(LA_W); i++)
         m[i] = ((CODE_W+1)'(i) >= n);
      return m;
   endfunction

   function automatic logic access_allowed(input logic [PERM_W-1:0] perm,
                                           input acc_e acc,
                                           input logic sup);
      logic [2:0] grp;
      grp = sup ? perm[5:3] : perm[2:0];
      case (acc)
         ACC_READ:  return grp[2];
         ACC_WRITE: return grp[1];
         ACC_EXEC:  return grp[0];
         default:   return 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/segx_regfile.sv
module segx_regfile
   import segx_pkg::*;
#(
   parameter int unsigned NUM_SEG = 16,
   localparam int unsigned IDX_W  = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1,
   localparam int unsigned AW     = IDX_W + 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [AW-1:0]     addr,
   input  logic [31:0]       wdata,
   output logic [31:0]       rdata,
   output seg_desc_t         desc [NUM_SEG]
);

   logic [IDX_W-1:0] sel_idx;
   logic             sel_hi;

   assign sel_idx = addr[AW-1:3];
   assign sel_hi  = addr[2];

   for (genvar g = 0; g < int'(NUM_SEG); g++) begin : g_seg
      logic hit_slot;
      assign hit_slot = we && (sel_idx == IDX_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            desc[g] <= '0;
         end else if (hit_slot) begin
            if (sel_hi) begin
               desc[g].pbase <= wdata[31:8];
               desc[g].perm  <= wdata[PERM_W-1:0];
            end else begin
               desc[g].lbase <= wdata[31:PAGE_W];
               desc[g].code  <= wdata[CODE_W-1:0];
            end
         end
      end
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < int'(NUM_SEG); i++) begin
         if (sel_idx == IDX_W'(i)) begin
            if (sel_hi)
               rdata = {desc[i].pbase, 2'b00, desc[i].perm};
            else
               rdata = {desc[i].lbase, 7'b0, desc[i].code};
         end
      end
   end

endmodule

// File: rtl/segx_match.sv
module segx_match
   import segx_pkg::*;
#(
   parameter int unsigned NUM_SEG = 16
) (
   input  seg_desc_t          desc [NUM_SEG],
   input  logic [LA_W-1:0]    addr,
   output logic [NUM_SEG-1:0] hit_vec,
   output logic [PA_W-1:0]    pa_seg [NUM_SEG]
);

   localparam int unsigned EXT_W = PA_W - LA_W;

   for (genvar g = 0; g < int'(NUM_SEG); g++) begin : g_cmp
      logic [LA_W-1:0] mask;
      logic            enabled;
      logic [LA_W-1:0] lbase_full;
      logic [PA_W-1:0] pbase_full;

      always_comb begin
         mask       = cmp_mask(desc[g].code);
         enabled    = (desc[g].code >= MIN_CODE);
         lbase_full = {desc[g].lbase, {PAGE_W{1'b0}}};
         pbase_full = {desc[g].pbase, {PAGE_W{1'b0}}};
         hit_vec[g] = enabled && ((addr & mask) == (lbase_full & mask));
         pa_seg[g]  = (pbase_full & {{EXT_W{1'b1}}, mask})
                    | {{EXT_W{1'b0}}, addr & ~mask};
      end
   end

endmodule

// File: rtl/segx_select.sv
module segx_select
   import segx_pkg::*;
#(
   parameter int unsigned NUM_SEG = 16
) (
   input  seg_desc_t          desc [NUM_SEG],
   input  logic [NUM_SEG-1:0] hit_vec,
   input  logic [PA_W-1:0]    pa_seg [NUM_SEG],
   output logic               any_hit,
   output logic [PA_W-1:0]    paddr,
   output logic [PERM_W-1:0]  perm
);

   // Ascending scan: a later (higher-numbered) hit overrides an earlier one.
   always_comb begin
      any_hit = 1'b0;
      paddr   = '0;
      perm    = '0;
      for (int i = 0; i < int'(NUM_SEG); i++) begin
         if (hit_vec[i]) begin
            any_hit = 1'b1;
            paddr   = pa_seg[i];
            perm    = desc[i].perm;
         end
      end
   end

endmodule

// File: rtl/segx_unit.sv
module segx_unit
   import segx_pkg::*;
#(
   parameter int unsigned NUM_SEG    = 16,
   parameter bit          LOOKUP_REG = 1'b1,
   localparam int unsigned IDX_W     = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1,
   localparam int unsigned AW        = IDX_W + 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cfg_we,
   input  logic [AW-1:0]   cfg_addr,
   input  logic [31:0]     cfg_wdata,
   output logic [31:0]     cfg_rdata,
   input  logic            lk_valid,
   input  logic [31:0]     lk_addr,
   input  logic [1:0]      lk_acc,
   input  logic            lk_priv,
   output logic            res_valid,
   output logic            res_hit,
   output logic            res_fault,
   output logic [35:0]     res_paddr
);

   if (NUM_SEG < 1 || NUM_SEG > 64) begin : g_bad_count
      $error("segx_unit: NUM_SEG out of range");
   end
   if (LA_W != 32 || PA_W != 36) begin : g_bad_width
      $error("segx_unit: descriptor layout needs 32-bit logical, 36-bit physical");
   end

   seg_desc_t         desc [NUM_SEG];
   logic [NUM_SEG-1:0] hit_vec;
   logic [PA_W-1:0]   pa_seg [NUM_SEG];
   logic              c_hit;
   logic [PA_W-1:0]   c_paddr;
   logic [PERM_W-1:0] c_perm;
   logic              c_fault;

   segx_regfile #(.NUM_SEG(NUM_SEG)) regs_i (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we),
      .addr  (cfg_addr),
      .wdata (cfg_wdata),
      .rdata (cfg_rdata),
      .desc  (desc)
   );

   segx_match #(.NUM_SEG(NUM_SEG)) match_i (
      .desc    (desc),
      .addr    (lk_addr),
      .hit_vec (hit_vec),
      .pa_seg  (pa_seg)
   );

   segx_select #(.NUM_SEG(NUM_SEG)) sel_i (
      .desc    (desc),
      .hit_vec (hit_vec),
      .pa_seg  (pa_seg),
      .any_hit (c_hit),
      .paddr   (c_paddr),
      .perm    (c_perm)
   );

   assign c_fault = c_hit && !access_allowed(c_perm, acc_e'(lk_acc), lk_priv);

   if (LOOKUP_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            res_valid <= 1'b0;
            res_hit   <= 1'b0;
            res_fault <= 1'b0;
            res_paddr <= '0;
         end else begin
            res_valid <= lk_valid;
            res_hit   <= lk_valid && c_hit;
            res_fault <= lk_valid && c_fault;
            if (lk_valid)
               res_paddr <= c_paddr;
         end
      end
   end else begin : g_comb
      assign res_valid = lk_valid;
      assign res_hit   = lk_valid && c_hit;
      assign res_fault = lk_valid && c_fault;
      assign res_paddr = c_paddr;
   end

endmodule

// File: rtl/segx_checker.sv
module segx_checker #(
   parameter bit LOOKUP_REG = 1'b1,
   parameter int unsigned AW = 7
) (
   input logic          clk,
   input logic          rst_n,
   input logic [AW-1:0] cfg_addr,
   input logic [31:0]   cfg_rdata,
   input logic          lk_valid,
   input logic [31:0]   lk_addr,
   input logic          res_valid,
   input logic          res_hit,
   input logic          res_fault,
   input logic [35:0]   res_paddr
);

   AST_FAULT_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      res_fault |-> res_hit);   // R9

   AST_RSVD_LO_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_addr[2] |-> (cfg_rdata[11:5] == 7'b0));   // R3

   AST_RSVD_HI_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_addr[2] |-> (cfg_rdata[7:6] == 2'b0));   // R3

   if (LOOKUP_REG) begin : g_reg_chk
      AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
         lk_valid |=> res_valid);   // R10

      AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
         !lk_valid |=> !res_valid);   // R10

      AST_PAGE_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
         lk_valid |=> (!res_hit || res_paddr[11:0] == $past(lk_addr[11:0])));   // R6
   end else begin : g_comb_chk
      AST_PAGE_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
         res_hit |-> (res_paddr[11:0] == lk_addr[11:0]));   // R6
   end

endmodule

bind segx_unit segx_checker #(.LOOKUP_REG(LOOKUP_REG), .AW(AW)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_addr  (cfg_addr),
   .cfg_rdata (cfg_rdata),
   .lk_valid  (lk_valid),
   .lk_addr   (lk_addr),
   .res_valid (res_valid),
   .res_hit   (res_hit),
   .res_fault (res_fault),
   .res_paddr (res_paddr)
);

// File: tb/segx_unit_tb_top.sv
`timescale 1ns/1ps
module segx_unit_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [6:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        lk_valid = 1'b0;
   logic [31:0] lk_addr = '0;
   logic [1:0]  lk_acc = '0;
   logic        lk_priv = 1'b0;
   logic        res_valid, res_hit, res_fault;
   logic [35:0] res_paddr;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   segx_unit dut_i (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_acc(lk_acc), .lk_priv(lk_priv),
      .res_valid(res_valid), .res_hit(res_hit), .res_fault(res_fault), .res_paddr(res_paddr)
   );

   // {addr, acc, priv, exp_hit, exp_fault, exp_paddr}
   localparam int NV = 14;
   localparam logic [72:0] VEC [NV] = '{
      {32'h80000010, 2'd0, 1'b0, 1'b1, 1'b0, 36'h0_4000_0010},
      {32'hBFFFFFFC, 2'd1, 1'b1, 1'b1, 1'b0, 36'h0_7FFF_FFFC},
      {32'hC0000000, 2'd0, 1'b1, 1'b0, 1'b0, 36'h0},
      {32'hE00ABCDE, 2'd1, 1'b0, 1'b1, 1'b0, 36'h0_0C0A_BCDE},
      {32'hE00FFFFF, 2'd2, 1'b1, 1'b1, 1'b1, 36'h0_0C0F_FFFF},
      {32'hE0100000, 2'd0, 1'b1, 1'b0, 1'b0, 36'h0},
      {32'h80001ABC, 2'd0, 1'b1, 1'b1, 1'b0, 36'h9_1234_5ABC},
      {32'h80001ABC, 2'd1, 1'b1, 1'b1, 1'b1, 36'h9_1234_5ABC},
      {32'h80001ABC, 2'd0, 1'b0, 1'b1, 1'b1, 36'h9_1234_5ABC},
      {32'h80002000, 2'd0, 1'b0, 1'b1, 1'b0, 36'h0_4000_2000},
      {32'h10000000, 2'd0, 1'b1, 1'b0, 1'b0, 36'h0},
      {32'h7FFFFFFF, 2'd2, 1'b0, 1'b0, 1'b0, 36'h0},
      {32'h80000000, 2'd2, 1'b0, 1'b1, 1'b0, 36'h0_4000_0000},
      {32'h80000010, 2'd3, 1'b1, 1'b1, 1'b1, 36'h0_4000_0010}
   };

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cfg_write(input logic [6:0] off, input logic [31:0] data);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = off; cfg_wdata = data;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic cfg_read(input logic [6:0] off, output logic [31:0] data);
      @(negedge clk);
      cfg_addr = off;
      #1 data = cfg_rdata;
   endtask

   task automatic lookup(input logic [31:0] a, input logic [1:0] acc, input logic priv,
                         output logic v, output logic h, output logic f, output logic [35:0] p);
      @(negedge clk);
      lk_valid = 1'b1; lk_addr = a; lk_acc = acc; lk_priv = priv;
      @(negedge clk);
      v = res_valid; h = res_hit; f = res_fault; p = res_paddr;
      lk_valid = 1'b0;
   endtask

   task automatic summary();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         summary();
         $finish;
      end
   end

   initial begin
      logic [31:0] rd;
      logic v, h, f;
      logic [35:0] p;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // Reset state
      chk("R10 reset valid", 64'(res_valid), 64'd0);
      cfg_read(7'h08, rd); chk("R1 reset word lo", 64'(rd), 64'd0);
      cfg_read(7'h0C, rd); chk("R1 reset word hi", 64'(rd), 64'd0);
      lookup(32'h80000010, 2'd0, 1'b1, v, h, f, p);
      chk("R1 reset miss hit", 64'(h), 64'd0);
      chk("R1 reset miss fault", 64'(f), 64'd0);

      // Program segments
      cfg_write(7'h08, 32'h8000001D);   // seg1: 1 GB at 0x80000000
      cfg_write(7'h0C, 32'h0400003F);   // phys 0x0_4000_0000, full access
      cfg_write(7'h10, 32'h10000005);   // seg2: code 5, disabled
      cfg_write(7'h14, 32'h0010003F);
      cfg_write(7'h18, 32'hE0000013);   // seg3: 1 MB at 0xE0000000
      cfg_write(7'h1C, 32'h00C00036);   // phys 0x0_0C00_0000, rw only
      cfg_write(7'h28, 32'h8000100B);   // seg5: 4 KB at 0x80001000
      cfg_write(7'h2C, 32'h91234520);   // phys 0x9_1234_5000, sup read only

      cfg_read(7'h18, rd); chk("R2 readback seg3 lo", 64'(rd), 64'hE0000013);
      cfg_read(7'h1C, rd); chk("R2 readback seg3 hi", 64'(rd), 64'h00C00036);

      // Vector table: R4 R5 R6 R7 R8 R9 R10
      for (int i = 0; i < NV; i++) begin
         logic [72:0] e;
         e = VEC[i];
         lookup(e[72:41], e[40:39], e[38], v, h, f, p);
         chk($sformatf("R10 vec%0d valid", i), 64'(v), 64'd1);
         chk($sformatf("R5 R4 R7 vec%0d hit", i), 64'(h), 64'(e[37]));
         chk($sformatf("R8 R9 vec%0d fault", i), 64'(f), 64'(e[36]));
         if (e[37])
            chk($sformatf("R6 vec%0d paddr", i), 64'(p), 64'(e[35:0]));
      end
      @(negedge clk);
      chk("R10 valid drops", 64'(res_valid), 64'd0);

      // Reserved bits read as zero
      cfg_write(7'h48, 32'hFFFFFFFF);
      cfg_write(7'h4C, 32'hFFFFFFFF);
      cfg_read(7'h48, rd); chk("R3 rsvd lo word", 64'(rd), 64'hFFFFF01F);
      cfg_read(7'h4C, rd); chk("R3 rsvd hi word", 64'(rd), 64'hFFFFFF3F);
      lookup(32'h80001ABC, 2'd1, 1'b0, v, h, f, p);
      chk("R7 seg9 over seg5 fault", 64'(f), 64'd0);
      chk("R6 seg9 paddr", 64'(p), 64'hF_8000_1ABC);

      // 4 GB segment 15, execute only
      cfg_write(7'h78, 32'h0000001F);
      cfg_write(7'h7C, 32'hA0000009);
      lookup(32'h12345678, 2'd2, 1'b0, v, h, f, p);
      chk("R4 4GB hit", 64'(h), 64'd1);
      chk("R8 4GB user exec", 64'(f), 64'd0);
      chk("R6 4GB paddr", 64'(p), 64'hA_1234_5678);
      lookup(32'h80001ABC, 2'd0, 1'b0, v, h, f, p);
      chk("R7 seg15 wins fault", 64'(f), 64'd1);
      chk("R7 seg15 wins paddr", 64'(p), 64'hA_8000_1ABC);
      lookup(32'hFFFFFFFF, 2'd2, 1'b1, v, h, f, p);
      chk("R8 4GB sup exec", 64'(f), 64'd0);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule